// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents one interrupt level and one vector number to the processor. Each source carries an 8-bit control byte that is its priority level. A non-zero byte also enables the source. A source counts as active when it is requesting, enabled and unmasked. Among the active sources, the one with the largest control byte wins. When two active sources share a level, the higher-numbered one wins.

Software reaches the block through a 32-bit register bus with an 8-bit byte offset. Through this bus it can read the pending, mask and force words, set either half of the 64-bit mask, and write or read the control bytes. A software acknowledge read returns the current vector. The mask resets to all ones, so no source can interrupt until software unmasks it and gives it a non-zero control byte. Illegal writes and reads of the per-level acknowledge offsets raise a one-cycle error pulse and change no state.

Top module: `intc_top`

## Requirements
- R1: A source is active only when its pending bit or force bit is 1, its enable bit is 1, and its mask bit is 0.
- R2: The winner is the active source with the largest control byte. On equal bytes, the source with the higher index wins.
- R3: `irq_vector` is the winner's index plus 64. With no active source, `irq_vector` is 24 and `irq_level` is 0.
- R4: `irq_level` equals the control byte of the winning source.
- R5: A write to offset 0x40+n stores `bus_wdata[7:0]` as the control byte of source n, readable at the same offset in bits 7:0. A zero byte clears the enable of source n and a non-zero byte sets it.
- R6: The following reads are decoded:
  - 0x00 returns pending bits 63:32 and 0x04 returns pending bits 31:0.
  - 0x08 returns mask bits 63:32 and 0x0C returns mask bits 31:0.
  - 0x10 returns force bits 63:32 and 0x14 returns force bits 31:0. The force word has no write path and stays 0.
  - 0xE0 returns the current vector in bits 7:0.
  - Read data is valid during the cycle in which `bus_rd` is high.
- R7: Each pending bit takes the value of its request line at every clock edge. Writes to 0x00 and 0x04 are ignored and raise no error.
- R8: After reset:
  - The mask is all ones.
  - Pending, force, enable and every control byte are 0.
  - `irq_level` is 0 and `irq_vector` is 24.
- R9: A write to 0x08 replaces mask bits 63:32 and a write to 0x0C replaces mask bits 31:0. Each write leaves the other half unchanged.
- R10: A read of any offset that R5, R6 and R11 do not name returns 0 and raises no error.
- R11: A write to an offset other than 0x00, 0x04, 0x08, 0x0C or 0x40–0x7F raises `bus_err`, as does a read of 0xE1–0xE7. In both cases `bus_err` is high for exactly the cycle after the access and no register changes.
- R12: `irq_level` and `irq_vector` depend only on registered state. They change one clock edge after a change on the request lines or a register write, and never within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| irq_level | output | 8 | Level of the winning source, 0 when idle |
| irq_vector | output | 8 | Vector number of the winning source, 24 when idle |

## Verification
The assertions assume that the request lines are synchronous to `clk`. They also assume that `bus_rd` and `bus_wr` are never high together and that the offset and data stay steady for the whole access cycle. The bench changes every input just after a rising edge and issues one access per cycle. It never raises both strobes at once and drives the request lines only from its own synchronous tasks.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int N_SRC    = 64;
  localparam int LVL_W    = 8;
  localparam int IDX_W    = $clog2(N_SRC);
  localparam int VEC_W    = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;

  localparam int VEC_BASE     = 64;
  localparam int VEC_SPURIOUS = 24;

  localparam logic [ADDR_W-1:0] OFF_PEND_HI    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_FORCE_HI   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FORCE_LO   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CTL_BASE   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_ACK        = 8'hE0;
  localparam logic [ADDR_W-1:0] OFF_LACK_FIRST = 8'hE1;
  localparam logic [ADDR_W-1:0] OFF_LACK_LAST  = 8'hE7;

  // Tree node choice: take the upper (higher-index) child on a tie.
  function automatic logic pick_upper(input logic [LVL_W-1:0] lvl_lower,
                                      input logic [LVL_W-1:0] lvl_upper);
    return lvl_upper >= lvl_lower;
  endfunction

  // Vector number for a winner, or the spurious vector when none.
  function automatic logic [VEC_W-1:0] encode_vector(input logic found,
                                                     input logic [IDX_W-1:0] idx);
    if (found) return VEC_W'(idx) + VEC_W'(VEC_BASE);
    return VEC_W'(VEC_SPURIOUS);
  endfunction

  // Per-level acknowledge offsets are not served.
  function automatic logic is_level_ack(input logic [ADDR_W-1:0] addr);
    return (addr >= OFF_LACK_FIRST) && (addr <= OFF_LACK_LAST);
  endfunction

endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int N = intc_pkg::N_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] pend_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= req;
  end

  AST_PEND_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_q == $past(req));  // R7

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N  = intc_pkg::N_SRC,
  parameter int LW = intc_pkg::LVL_W,
  parameter int DW = intc_pkg::DATA_W,
  parameter int AW = intc_pkg::ADDR_W,
  parameter int VW = intc_pkg::VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  pend,
  input  logic [VW-1:0] vector,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  force_q,
  output logic [N-1:0]  en_q,
  output logic [N*LW-1:0] ctl_flat,
  output logic [DW-1:0] rdata,
  output logic          err_q
);

  localparam int HALF = N / 2;
  localparam int IW   = $clog2(N);

  logic [LW-1:0] ctl_q [N];
  logic [AW-1:0] ctl_off;
  logic [IW-1:0] ctl_sel;
  logic          ctl_hit;
  logic          wr_legal;
  logic          illegal_wr;
  logic          illegal_rd;
  logic          ctl_wr;
  logic          mask_hi_wr;
  logic          mask_lo_wr;
  logic          pend_wr;

  // Address decode
  assign ctl_off  = addr - OFF_CTL_BASE;
  assign ctl_sel  = ctl_off[IW-1:0];
  assign ctl_hit  = (addr >= OFF_CTL_BASE) && (ctl_off < AW'(N));

  assign mask_hi_wr = wr && (addr == OFF_MASK_HI);
  assign mask_lo_wr = wr && (addr == OFF_MASK_LO);
  assign pend_wr    = wr && ((addr == OFF_PEND_HI) || (addr == OFF_PEND_LO));
  assign ctl_wr     = wr && ctl_hit;

  assign wr_legal   = ctl_hit || (addr == OFF_MASK_HI) || (addr == OFF_MASK_LO) ||
                      (addr == OFF_PEND_HI) || (addr == OFF_PEND_LO);
  assign illegal_wr = wr && !wr_legal;
  assign illegal_rd = rd && is_level_ack(addr);

  // Mask halves
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      if (mask_hi_wr) mask_q[N-1:HALF] <= wdata[HALF-1:0];
      if (mask_lo_wr) mask_q[HALF-1:0] <= wdata[HALF-1:0];
    end
  end

  // Force word: readable, no write path
  always_ff @(posedge clk) begin
    if (!rst_n) force_q <= '0;
    else        force_q <= force_q;
  end

  // Control bytes and implied enables
  for (genvar i = 0; i < N; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end else if (ctl_wr && (ctl_sel == IW'(i))) begin
        ctl_q[i] <= wdata[LW-1:0];
        en_q[i]  <= |wdata[LW-1:0];
      end
    end
    assign ctl_flat[i*LW +: LW] = ctl_q[i];

    AST_EN_TRACKS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] == (ctl_q[i] != '0));  // R5
  end

  // Error pulse
  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= illegal_wr || illegal_rd;
  end

  // Read mux
  always_comb begin
    rdata = '0;
    if (rd) begin
      if (ctl_hit) begin
        rdata = DW'(ctl_q[ctl_sel]);
      end else begin
        case (addr)
          OFF_PEND_HI:  rdata = pend[N-1:HALF];
          OFF_PEND_LO:  rdata = pend[HALF-1:0];
          OFF_MASK_HI:  rdata = mask_q[N-1:HALF];
          OFF_MASK_LO:  rdata = mask_q[HALF-1:0];
          OFF_FORCE_HI: rdata = force_q[N-1:HALF];
          OFF_FORCE_LO: rdata = force_q[HALF-1:0];
          OFF_ACK:      rdata = DW'(vector);
          default:      rdata = '0;
        endcase
      end
    end
  end

  AST_MASK_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    mask_lo_wr |=> mask_q[N-1:HALF] == $past(mask_q[N-1:HALF]));  // R9
  AST_MASK_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hi_wr |=> mask_q[HALF-1:0] == $past(mask_q[HALF-1:0]));  // R9
  AST_ERR_AFTER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_wr || illegal_rd) |=> err_q);  // R11
  AST_ILLEGAL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> $stable(mask_q) && $stable(ctl_flat));  // R11
  AST_PEND_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && !rd) |=> !err_q);  // R7
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    force_q == '0);  // R6

endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
  import intc_pkg::*;
#(
  parameter int N  = intc_pkg::N_SRC,
  parameter int LW = intc_pkg::LVL_W
) (
  input  logic [N-1:0]          active,
  input  logic [N*LW-1:0]       ctl_flat,
  output logic                  found,
  output logic [$clog2(N)-1:0]  win_idx,
  output logic [LW-1:0]         win_lvl
);

  localparam int IW    = $clog2(N);
  localparam int NODES = 2 * N - 1;

  // Heap-ordered tournament: node k has children 2k+1 (lower) and 2k+2 (upper).
  logic [LW-1:0] node_lvl [NODES];
  logic [IW-1:0] node_idx [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node_lvl[N-1+i] = active[i] ? ctl_flat[i*LW +: LW] : '0;
    assign node_idx[N-1+i] = IW'(i);
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_node
    logic take_upper;
    assign take_upper  = pick_upper(node_lvl[2*k+1], node_lvl[2*k+2]);
    assign node_lvl[k] = take_upper ? node_lvl[2*k+2] : node_lvl[2*k+1];
    assign node_idx[k] = take_upper ? node_idx[2*k+2] : node_idx[2*k+1];
  end

  // An active source is enabled, so its byte is non-zero.
  assign found   = node_lvl[0] != '0;
  assign win_lvl = node_lvl[0];
  assign win_idx = node_idx[0];

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N  = intc_pkg::N_SRC,
  parameter int LW = intc_pkg::LVL_W,
  parameter int DW = intc_pkg::DATA_W,
  parameter int AW = intc_pkg::ADDR_W,
  parameter int VW = intc_pkg::VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic [LW-1:0] irq_level,
  output logic [VW-1:0] irq_vector
);

  localparam int IW = $clog2(N);

  logic [N-1:0]    pend_q;
  logic [N-1:0]    mask_q;
  logic [N-1:0]    force_q;
  logic [N-1:0]    en_q;
  logic [N*LW-1:0] ctl_flat;
  logic [N-1:0]    active;
  logic            found;
  logic [IW-1:0]   win_idx;
  logic [LW-1:0]   win_lvl;
  logic [VW-1:0]   vec_off;
  logic [IW-1:0]   vec_src;

  intc_pend #(.N(N)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (irq_req),
    .pend_q (pend_q)
  );

  intc_regs #(.N(N), .LW(LW), .DW(DW), .AW(AW), .VW(VW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pend     (pend_q),
    .vector   (irq_vector),
    .mask_q   (mask_q),
    .force_q  (force_q),
    .en_q     (en_q),
    .ctl_flat (ctl_flat),
    .rdata    (bus_rdata),
    .err_q    (bus_err)
  );

  assign active = (pend_q | force_q) & en_q & ~mask_q;

  intc_resolve #(.N(N), .LW(LW)) u_resolve (
    .active   (active),
    .ctl_flat (ctl_flat),
    .found    (found),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign irq_level  = found ? win_lvl : '0;
  assign irq_vector = encode_vector(found, win_idx);

  // Source named by the vector, for the checks below
  assign vec_off = irq_vector - VW'(VEC_BASE);
  assign vec_src = vec_off[IW-1:0];

  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (irq_vector == VW'(VEC_SPURIOUS)) && (irq_level == '0));  // R3
  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> active[vec_src]);  // R1
  AST_LEVEL_IS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> ctl_flat[vec_src*LW +: LW] == irq_level);  // R4

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_NO_HIGHER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active[i] |-> ctl_flat[i*LW +: LW] <= irq_level);  // R2
    AST_TIE_TO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (active[i] && (ctl_flat[i*LW +: LW] == irq_level)) |-> IW'(i) <= vec_src);  // R2
  end

endmodule

// File: tb/sim_intc_top.sv
module sim_intc_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 0 rdata, 1 level, 2 vector, 3 err
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_req;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  irq_level, irq_vector;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  sb_item_t sbq[$];

  // Bench model
  logic [63:0] m_req;
  logic [63:0] m_mask;
  logic [7:0]  m_ctl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .irq_level  (irq_level),
    .irq_vector (irq_vector)
  );

  // Monitor: compare queued expectations mid-cycle
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = 32'(irq_level);
        2:       act = 32'(irq_vector);
        default: act = 32'(bus_err);
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Scan from the top so the first strictly larger level keeps the higher index.
  task automatic ref_out(output logic [7:0] lvl, output logic [7:0] vec);
    lvl = 8'd0;
    vec = 8'd24;
    for (int i = 63; i >= 0; i--) begin
      if (m_req[i] && (m_ctl[i] != 8'd0) && !m_mask[i] && (m_ctl[i] > lvl)) begin
        lvl = m_ctl[i];
        vec = 8'(i + 64);
      end
    end
  endtask

  task automatic push_outs(input string tag);
    logic [7:0] l, v;
    ref_out(l, v);
    push(1, 32'(l), {tag, " level"});
    push(2, 32'(v), {tag, " vector"});
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
    if (a >= 8'h40 && a < 8'h80) m_ctl[a - 8'h40] = d[7:0];
    else if (a == 8'h08) m_mask[63:32] = d;
    else if (a == 8'h0C) m_mask[31:0] = d;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    push(0, exp, tag);
    step();
    bus_rd = 1'b0;
  endtask

  task automatic set_req(input logic [63:0] v);
    irq_req = v;
    step();
    m_req = v;
  endtask

  function automatic logic [31:0] ref_vec32();
    logic [7:0] best;
    logic [7:0] v;
    best = 8'd0;
    v = 8'd24;
    for (int i = 63; i >= 0; i--)
      if (m_req[i] && (m_ctl[i] != 8'd0) && !m_mask[i] && (m_ctl[i] > best)) begin
        best = m_ctl[i];
        v = 8'(i + 64);
      end
    return 32'(v);
  endfunction

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL R12 watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    m_req = '0; m_mask = '1;
    for (int i = 0; i < 64; i++) m_ctl[i] = 8'd0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R8 reset state
    push_outs("R8 reset");
    bus_read(8'h08, 32'hFFFF_FFFF, "R8 mask hi");
    bus_read(8'h0C, 32'hFFFF_FFFF, "R8 mask lo");
    bus_read(8'h14, 32'h0, "R8 force lo");
    bus_read(8'h45, 32'h0, "R8 ctl byte");
    bus_read(8'hE0, 32'd24, "R8 ack vector");

    // R1 masked source does not win
    bus_write(8'h45, 32'h3);
    set_req(64'h20);
    push_outs("R1 masked");
    bus_write(8'h0C, 32'h0);
    bus_write(8'h08, 32'h0);
    push_outs("R3 R4 single source");
    bus_read(8'hE0, ref_vec32(), "R6 ack after unmask");

    // R1 requesting but not enabled
    set_req(64'h20 | 64'h400);
    push_outs("R1 not enabled");

    // R2 tie goes to the higher index, then a higher level wins
    bus_write(8'h68, 32'h3);
    set_req(64'h0000_0100_0000_0420);
    push_outs("R2 tie");
    bus_write(8'h42, 32'h7);
    set_req(64'h0000_0100_0000_0424);
    push_outs("R2 higher level");

    // R5 zero byte disables, readback of stored bytes
    bus_write(8'h42, 32'h0);
    push_outs("R5 zero disables");
    bus_read(8'h68, 32'h3, "R5 ctl readback");
    bus_write(8'h7F, 32'h1234_56A5);
    bus_read(8'h7F, 32'hA5, "R5 byte stored");

    // R9 half mask write
    bus_write(8'h08, 32'hFFFF_FFFF);
    push_outs("R9 hi masked");
    bus_read(8'h0C, 32'h0, "R9 lo kept");
    bus_read(8'h08, 32'hFFFF_FFFF, "R9 hi written");

    // R6 R7 pending words, ignored pending write
    bus_read(8'h04, 32'h0000_0424, "R7 pend lo");
    bus_read(8'h00, 32'h0000_0100, "R7 pend hi");
    bus_write(8'h04, 32'hDEAD_BEEF);
    push(3, 32'd1 - 32'd1, "R7 no err on pend write");
    bus_read(8'h04, 32'h0000_0424, "R7 pend write ignored");

    // R10 unlisted read
    bus_read(8'h20, 32'h0, "R10 unlisted read");
    push(3, 32'h0, "R10 no err");
    bus_read(8'hF0, 32'h0, "R10 unlisted high read");

    // R11 illegal write
    bus_write(8'h10, 32'hFFFF_FFFF);
    push(3, 32'h1, "R11 err after illegal write");
    step();
    push(3, 32'h0, "R11 err one cycle");
    bus_read(8'h10, 32'h0, "R11 force unchanged");
    bus_read(8'h0C, 32'h0, "R11 mask unchanged");
    bus_write(8'h3C, 32'h55);
    push(3, 32'h1, "R11 err after write 3C");
    push_outs("R11 outputs unchanged");
    // R11 level-ack read
    bus_read(8'hE3, 32'h0, "R11 level ack read data");
    push(3, 32'h1, "R11 err after level ack read");
    step();
    push(3, 32'h0, "R11 err drops");

    // R12 output latency
    bus_write(8'h08, 32'h0);
    set_req(64'h0);
    push_outs("R12 settle");
    irq_req = 64'h0000_0100_0000_0000;
    push_outs("R12 same cycle unchanged");
    step();
    m_req = irq_req;
    push_outs("R12 one edge later");

    // Mixed traffic against the model
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: set_req({$urandom, $urandom} & {$urandom, $urandom});
        1: bus_write(8'(8'h40 + $urandom_range(0, 63)),
                     ($urandom_range(0, 3) == 0) ? 32'h0 : 32'($urandom_range(1, 255)));
        2: bus_write(($urandom_range(0, 1) == 0) ? 8'h08 : 8'h0C,
                     $urandom & $urandom);
        default: bus_read(8'hE0, ref_vec32(), "R2 R3 ack random");
      endcase
      push_outs("R2 R4 random");
    end

    step();
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule